// File: doc/BRIEF.md
# Serial NAND Operation Sequencer

This block accepts one high-level request at a time (device reset, identification read, page read, page program or block erase) and expands it into the ordered list of single serial-flash operations that the request needs. Each operation is handed to an external operation engine as a descriptor: opcode, address and its byte count, dummy byte count, data direction, data length and, for register writes, the byte to write. The engine moves the bytes on the wire and answers with a completion strobe and, for register reads, the byte it read.

Wherever the device has to work internally, the sequencer reads the status register repeatedly until its busy bit drops. It then turns the final status byte into a result code. A bounded number of busy readings, set at a port, protects against a device that never becomes ready. A reset request also unlocks every block and turns on the device's internal error correction. Until one reset request has finished without timing out, every other request is refused.

Top module: `nand_seq`

## Requirements
- R1: After `rst_n` is released, `busy`, `done` and `op_valid` are low. A request of any kind other than reset (kind 0) is refused, meaning `busy` stays low and no operation is issued, until a reset request has ended with a non-timeout result.
- R2: A reset request issues, in order: opcode 0xFF with no address and no data; status polling; a register write of opcode 0x1F to register 0xA0 with data 0x00; and a register write 0x1F to register 0xB0 with data 0x10, which sets bit 4 to enable error correction. A register write carries a 1-byte address and 1 output byte.
- R3: A request of kind 1 issues opcode 0x9F with no address and `ID_DUMMY` dummy bytes, direction in. Its length is `req_len`, clamped to at most 4.
- R4: A request of kind 2 issues opcode 0x13 with the 3-byte row address, then status polling, then a cache read with the 2-byte column address, direction in, length `req_len`. The cache read is opcode 0x03 with no dummy when `req_opt` is 0, and 0x0B with `FAST_DUMMY` dummy bytes when `req_opt` is 1.
- R5: A request of kind 3 issues write enable 0x06, then a cache load with the 2-byte column address, direction out, length `req_len`, then opcode 0x10 with the 3-byte row address, then status polling. The cache load is 0x02 (clears the cache) when `req_opt` is 0 and 0x84 (keeps the cache) when it is 1.
- R6: A request of kind 4 issues write enable 0x06, then opcode 0xD8 with the 3-byte row address and no data, then status polling.
- R7: Every 0x10 and every 0xD8 operation is preceded by a 0x06 operation, with no other 0x10 or 0xD8 in between.
- R8: Status polling issues opcode 0x0F with 1-byte address 0xC0, direction in, length 1. It repeats while bit 0 of the returned byte is set. When the number of busy readings in one polling phase reaches `poll_limit`, the request ends at once with result 5 and no further operation.
- R9: The result is as follows. Reset and identification end with 0. A page read maps status bits 5:4 of its poll to 0 (value 0), 1 (value 1) or 2 (value 2 or 3). A program ends with 3 if status bit 3 is set, else 0. An erase ends with 4 if status bit 2 is set, else 0.
- R10: While `op_valid` is high and `op_ready` low, the descriptor holds still. An operation is taken on `op_valid && op_ready`, and the next one is offered only after `op_done`.
- R11: At the end of a request, `done` pulses for one cycle with `busy` already low, and `result` holds its value until the next end. Requests that arrive while `busy` is high, and request kinds 5 to 7, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_kind | input | 3 | 0 reset, 1 identify, 2 page read, 3 program, 4 erase |
| req_opt | input | 1 | Fast cache read (read) or keep cache (program) |
| req_row | input | 24 | Page or block row address |
| req_col | input | 16 | Column address inside the page |
| req_len | input | LEN_W | Data byte count |
| poll_limit | input | POLL_W | Busy readings allowed per polling phase |
| op_valid | output | 1 | Descriptor offered to the engine |
| op_ready | input | 1 | Engine takes the descriptor |
| op_cmd | output | 8 | Opcode |
| op_addr | output | 24 | Address value, right aligned |
| op_addr_len | output | 2 | Address bytes |
| op_dummy_len | output | 2 | Dummy bytes |
| op_dir | output | 2 | 0 no data, 1 data in, 2 data out |
| op_len | output | LEN_W | Data byte count |
| op_wbyte | output | 8 | Byte written by a register write |
| op_done | input | 1 | Engine finished the taken operation |
| op_rdata | input | 8 | First byte read by that operation |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| result | output | 3 | Outcome code of the last request |

## Verification
A step counter that skips a step, or a wrong opcode variant, shows up at the next descriptor the engine takes. This happens within one operation of the fault, so the bench compares the whole descriptor log of every request against a sequence it builds itself. A poll counter that is off by one makes the number of status reads differ from `poll_limit`, or hides the timeout code, by the end of that polling phase. A wrong decode of the held status byte, or a lost initialisation flag, shows up at the very next `done` pulse or at the next refused request.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam logic [2:0] KIND_RESET = 3'd0;
  localparam logic [2:0] KIND_IDENT = 3'd1;
  localparam logic [2:0] KIND_READ  = 3'd2;
  localparam logic [2:0] KIND_PROG  = 3'd3;
  localparam logic [2:0] KIND_ERASE = 3'd4;

  localparam logic [2:0] RES_OK      = 3'd0;
  localparam logic [2:0] RES_FIXED   = 3'd1;
  localparam logic [2:0] RES_UNCORR  = 3'd2;
  localparam logic [2:0] RES_PFAIL   = 3'd3;
  localparam logic [2:0] RES_EFAIL   = 3'd4;
  localparam logic [2:0] RES_TIMEOUT = 3'd5;

  localparam logic [1:0] DIR_NONE = 2'd0;
  localparam logic [1:0] DIR_IN   = 2'd1;
  localparam logic [1:0] DIR_OUT  = 2'd2;

  typedef enum logic [3:0] {
    ST_RESET, ST_WREN, ST_UNLOCK, ST_ECCON, ST_IDENT, ST_PGRD,
    ST_CACHERD, ST_LOAD, ST_EXEC, ST_ERASE, ST_POLL, ST_END
  } step_e;

  typedef struct packed {
    logic [7:0]  cmd;
    logic [23:0] addr;
    logic [1:0]  alen;
    logic [1:0]  dlen;
    logic [1:0]  dir;
    logic [15:0] len;
    logic [7:0]  wbyte;
  } desc_t;

  function automatic step_e plan_step(input logic [2:0] kind, input logic [2:0] idx);
    step_e s;
    s = ST_END;
    case (kind)
      KIND_RESET: case (idx)
        3'd0: s = ST_RESET;  3'd1: s = ST_POLL;
        3'd2: s = ST_UNLOCK; 3'd3: s = ST_ECCON;
        default: s = ST_END;
      endcase
      KIND_IDENT: s = (idx == 3'd0) ? ST_IDENT : ST_END;
      KIND_READ: case (idx)
        3'd0: s = ST_PGRD; 3'd1: s = ST_POLL; 3'd2: s = ST_CACHERD;
        default: s = ST_END;
      endcase
      KIND_PROG: case (idx)
        3'd0: s = ST_WREN; 3'd1: s = ST_LOAD;
        3'd2: s = ST_EXEC; 3'd3: s = ST_POLL;
        default: s = ST_END;
      endcase
      KIND_ERASE: case (idx)
        3'd0: s = ST_WREN; 3'd1: s = ST_ERASE; 3'd2: s = ST_POLL;
        default: s = ST_END;
      endcase
      default: s = ST_END;
    endcase
    return s;
  endfunction

  function automatic desc_t step_desc(input step_e s, input logic [23:0] row,
                                      input logic [15:0] col, input logic [15:0] len,
                                      input logic opt, input logic [1:0] id_dummy,
                                      input logic [1:0] fast_dummy);
    desc_t d;
    d = '0;
    case (s)
      ST_RESET:  d.cmd = 8'hFF;
      ST_WREN:   d.cmd = 8'h06;
      ST_UNLOCK: begin d.cmd = 8'h1F; d.addr = 24'hA0; d.alen = 2'd1;
                       d.dir = DIR_OUT; d.len = 16'd1; d.wbyte = 8'h00; end
      ST_ECCON:  begin d.cmd = 8'h1F; d.addr = 24'hB0; d.alen = 2'd1;
                       d.dir = DIR_OUT; d.len = 16'd1; d.wbyte = 8'h10; end
      ST_IDENT:  begin d.cmd = 8'h9F; d.dlen = id_dummy; d.dir = DIR_IN;
                       d.len = (len > 16'd4) ? 16'd4 : len; end
      ST_PGRD:   begin d.cmd = 8'h13; d.addr = row; d.alen = 2'd3; end
      ST_CACHERD: begin d.cmd = opt ? 8'h0B : 8'h03; d.addr = {8'h00, col};
                       d.alen = 2'd2; d.dlen = opt ? fast_dummy : 2'd0;
                       d.dir = DIR_IN; d.len = len; end
      ST_LOAD:   begin d.cmd = opt ? 8'h84 : 8'h02; d.addr = {8'h00, col};
                       d.alen = 2'd2; d.dir = DIR_OUT; d.len = len; end
      ST_EXEC:   begin d.cmd = 8'h10; d.addr = row; d.alen = 2'd3; end
      ST_ERASE:  begin d.cmd = 8'hD8; d.addr = row; d.alen = 2'd3; end
      ST_POLL:   begin d.cmd = 8'h0F; d.addr = 24'hC0; d.alen = 2'd1;
                       d.dir = DIR_IN; d.len = 16'd1; end
      default:   d = '0;
    endcase
    return d;
  endfunction

  function automatic logic [2:0] judge(input logic [2:0] kind, input logic [7:0] st);
    logic [2:0] r;
    r = RES_OK;
    case (kind)
      KIND_READ:  case (st[5:4])
        2'd0: r = RES_OK;
        2'd1: r = RES_FIXED;
        default: r = RES_UNCORR;
      endcase
      KIND_PROG:  r = st[3] ? RES_PFAIL : RES_OK;
      KIND_ERASE: r = st[2] ? RES_EFAIL : RES_OK;
      default:    r = RES_OK;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/nand_seq_steps.sv
module nand_seq_steps
  import nand_seq_pkg::*;
#(
  parameter int ID_DUMMY   = 1,
  parameter int FAST_DUMMY = 1
) (
  input  logic [2:0]  kind,
  input  logic [2:0]  idx,
  input  logic [23:0] row,
  input  logic [15:0] col,
  input  logic [15:0] len,
  input  logic        opt,
  output step_e       step_cur,
  output step_e       step_next,
  output desc_t       desc
);
  localparam logic [1:0] ID_D   = 2'(ID_DUMMY);
  localparam logic [1:0] FAST_D = 2'(FAST_DUMMY);

  assign step_cur  = plan_step(kind, idx);
  assign step_next = plan_step(kind, idx + 3'd1);
  assign desc      = step_desc(step_cur, row, col, len, opt, ID_D, FAST_D);
endmodule

// File: rtl/nand_seq_poll.sv
module nand_seq_poll #(
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              busy_seen,
  input  logic [POLL_W-1:0] limit,
  output logic              expired
);
  logic [POLL_W-1:0] cnt_q;
  logic [POLL_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{POLL_W{1'b0}}, 1'b1};
  assign expired = busy_seen && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clear)     cnt_q <= '0;
    else if (busy_seen) cnt_q <= cnt_inc[POLL_W-1:0];
  end
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int LEN_W      = 13,
  parameter int POLL_W     = 16,
  parameter int ID_DUMMY   = 1,
  parameter int FAST_DUMMY = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic              req_opt,
  input  logic [23:0]       req_row,
  input  logic [15:0]       req_col,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [7:0]        op_cmd,
  output logic [23:0]       op_addr,
  output logic [1:0]        op_addr_len,
  output logic [1:0]        op_dummy_len,
  output logic [1:0]        op_dir,
  output logic [LEN_W-1:0]  op_len,
  output logic [7:0]        op_wbyte,
  input  logic              op_done,
  input  logic [7:0]        op_rdata,
  output logic              busy,
  output logic              done,
  output logic [2:0]        result
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} fsm_e;

  fsm_e              state_q;
  logic [2:0]        kind_q, idx_q, result_q;
  logic [23:0]       row_q;
  logic [15:0]       col_q;
  logic [LEN_W-1:0]  len_q;
  logic              opt_q, init_q, done_q;
  logic [7:0]        status_q;

  step_e step_cur, step_next;
  desc_t desc;

  logic kind_known, req_accept, op_fire, in_poll, answer;
  logic poll_busy_seen, poll_expired, poll_clear, seq_end;
  logic [7:0] final_status;
  logic [2:0] end_result;

  assign kind_known     = (req_kind <= KIND_ERASE);
  assign req_accept     = (state_q == S_IDLE) && req_valid && kind_known &&
                          (init_q || req_kind == KIND_RESET);
  assign op_fire        = op_valid && op_ready;
  assign in_poll        = (step_cur == ST_POLL);
  assign answer         = (state_q == S_WAIT) && op_done;
  assign poll_busy_seen = answer && in_poll && op_rdata[0];
  assign poll_clear     = (state_q == S_IDLE) || !in_poll;
  assign seq_end        = (step_next == ST_END);
  assign final_status   = in_poll ? op_rdata : status_q;
  assign end_result     = judge(kind_q, final_status);

  nand_seq_steps #(.ID_DUMMY(ID_DUMMY), .FAST_DUMMY(FAST_DUMMY)) u_steps (
    .kind(kind_q), .idx(idx_q), .row(row_q), .col(col_q),
    .len(16'(len_q)), .opt(opt_q),
    .step_cur(step_cur), .step_next(step_next), .desc(desc)
  );

  nand_seq_poll #(.POLL_W(POLL_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .clear(poll_clear),
    .busy_seen(poll_busy_seen), .limit(poll_limit), .expired(poll_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      kind_q   <= '0;
      idx_q    <= '0;
      row_q    <= '0;
      col_q    <= '0;
      len_q    <= '0;
      opt_q    <= 1'b0;
      status_q <= '0;
      init_q   <= 1'b0;
      done_q   <= 1'b0;
      result_q <= RES_OK;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (req_accept) begin
          kind_q   <= req_kind;
          row_q    <= req_row;
          col_q    <= req_col;
          len_q    <= req_len;
          opt_q    <= req_opt;
          idx_q    <= '0;
          status_q <= '0;
          state_q  <= S_ISSUE;
          if (req_kind == KIND_RESET) init_q <= 1'b0;
        end
        S_ISSUE: if (op_ready) state_q <= S_WAIT;
        S_WAIT: if (op_done) begin
          if (poll_busy_seen) begin
            if (poll_expired) begin
              state_q  <= S_IDLE;
              done_q   <= 1'b1;
              result_q <= RES_TIMEOUT;
            end else begin
              state_q <= S_ISSUE;
            end
          end else begin
            if (in_poll) status_q <= op_rdata;
            idx_q <= idx_q + 3'd1;
            if (seq_end) begin
              state_q  <= S_IDLE;
              done_q   <= 1'b1;
              result_q <= end_result;
              if (kind_q == KIND_RESET) init_q <= 1'b1;
            end else begin
              state_q <= S_ISSUE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign op_valid     = (state_q == S_ISSUE);
  assign op_cmd       = desc.cmd;
  assign op_addr      = desc.addr;
  assign op_addr_len  = desc.alen;
  assign op_dummy_len = desc.dlen;
  assign op_dir       = desc.dir;
  assign op_len       = desc.len[LEN_W-1:0];
  assign op_wbyte     = desc.wbyte;
  assign busy         = (state_q != S_IDLE);
  assign done         = done_q;
  assign result       = result_q;
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic        op_ready,
  input logic        op_done,
  input logic [7:0]  op_cmd,
  input logic [23:0] op_addr,
  input logic        busy,
  input logic        done,
  input logic [2:0]  result,
  input logic        op_fire,
  input logic        poll_expired,
  input logic        init_q
);
  logic wen_armed, outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_armed   <= 1'b0;
      outstanding <= 1'b0;
    end else begin
      if (op_fire && op_cmd == 8'h06) wen_armed <= 1'b1;
      else if (op_fire && (op_cmd == 8'h10 || op_cmd == 8'hD8)) wen_armed <= 1'b0;
      if (op_fire) outstanding <= 1'b1;
      else if (op_done) outstanding <= 1'b0;
    end
  end

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !op_valid);
  assert_init_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && !init_q) |-> (op_cmd == 8'hFF || op_cmd == 8'h0F || op_cmd == 8'h1F));
  assert_wen_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && (op_cmd == 8'h10 || op_cmd == 8'hD8)) |-> wen_armed);
  assert_timeout_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    poll_expired |=> (done && result == 3'd5));
  assert_hold_desc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_cmd) && $stable(op_addr)));
  assert_single_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |-> !outstanding);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind nand_seq nand_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_done(op_done), .op_cmd(op_cmd), .op_addr(op_addr), .busy(busy),
  .done(done), .result(result), .op_fire(op_fire),
  .poll_expired(poll_expired), .init_q(init_q)
);

// File: tb/nand_seq_bench.sv
module nand_seq_bench;
  localparam int LEN_W = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_opt = 0;
  logic [2:0] req_kind = 0;
  logic [23:0] req_row = 0;
  logic [15:0] req_col = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic [15:0] poll_limit = 16'd6;
  logic op_valid, op_ready = 0, op_done = 0;
  logic [7:0] op_cmd, op_wbyte, op_rdata = 0;
  logic [23:0] op_addr;
  logic [1:0] op_addr_len, op_dummy_len, op_dir;
  logic [LEN_W-1:0] op_len;
  logic busy, done;
  logic [2:0] result;

  nand_seq u_nand_seq (.*);

  int checks = 0, errors = 0;
  logic [61:0] act_log [64];
  logic [61:0] exp_log [64];
  int act_n = 0, exp_n = 0;
  int busy_left = 0;
  logic [7:0] final_st = 0;

  function automatic logic [61:0] pk(logic [7:0] c, logic [23:0] a, logic [1:0] al,
                                     logic [1:0] dl, logic [1:0] dr, logic [15:0] ln,
                                     logic [7:0] wb);
    return {c, a, al, dl, dr, ln, wb};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // operation engine model
  initial begin
    int pend = 0, dly = 0;
    forever begin
      @(negedge clk);
      op_done = 0;
      if (pend != 0) begin
        op_ready = 0;
        if (dly == 0) begin
          op_done = 1; pend = 0;
          if (act_n > 0 && act_log[act_n-1][61:54] == 8'h0F) begin
            if (busy_left > 0) begin
              op_rdata = {7'($urandom), 1'b1}; busy_left--;
            end else op_rdata = final_st;
          end else op_rdata = 8'($urandom);
        end else dly--;
      end else if (op_valid) begin
        op_ready = 1'($urandom);
        if (op_ready) begin
          if (act_n < 64) act_log[act_n] = pk(op_cmd, op_addr, op_addr_len, op_dummy_len,
                                              op_dir, 16'(op_len), op_wbyte);
          act_n++; pend = 1; dly = $urandom % 3;
        end
      end else op_ready = 0;
    end
  end

  task automatic push(logic [61:0] e);
    exp_log[exp_n] = e; exp_n++;
  endtask

  function automatic logic [2:0] exp_result(logic [2:0] k, logic [7:0] st, bit tmo);
    if (tmo) return 3'd5;
    case (k)
      3'd2: return (st[5:4] == 2'd0) ? 3'd0 : (st[5:4] == 2'd1) ? 3'd1 : 3'd2;
      3'd3: return st[3] ? 3'd3 : 3'd0;
      3'd4: return st[2] ? 3'd4 : 3'd0;
      default: return 3'd0;
    endcase
  endfunction

  task automatic run_req(logic [2:0] k, logic opt, logic [23:0] row, logic [15:0] col,
                         logic [LEN_W-1:0] len, int nbusy, logic [7:0] st,
                         bit intrude, string tag);
    bit tmo, seen;
    int npoll;
    logic [2:0] rsl;
    logic [61:0] pollop;
    pollop = pk(8'h0F, 24'hC0, 2'd1, 2'd0, 2'd1, 16'd1, 8'h00);
    tmo = (nbusy >= int'(poll_limit)) && (k != 3'd1);
    npoll = tmo ? int'(poll_limit) : nbusy + 1;
    exp_n = 0;
    case (k)
      3'd0: push(pk(8'hFF, 0, 0, 0, 0, 0, 0));
      3'd1: push(pk(8'h9F, 0, 0, 2'd1, 2'd1, (len > 4) ? 16'd4 : 16'(len), 0));
      3'd2: push(pk(8'h13, row, 2'd3, 0, 0, 0, 0));
      3'd3: begin push(pk(8'h06, 0, 0, 0, 0, 0, 0));
                  push(pk(opt ? 8'h84 : 8'h02, {8'h0, col}, 2'd2, 0, 2'd2, 16'(len), 0));
                  push(pk(8'h10, row, 2'd3, 0, 0, 0, 0)); end
      default: begin push(pk(8'h06, 0, 0, 0, 0, 0, 0));
                     push(pk(8'hD8, row, 2'd3, 0, 0, 0, 0)); end
    endcase
    if (k != 3'd1) for (int i = 0; i < npoll; i++) push(pollop);
    if (!tmo) begin
      if (k == 3'd0) begin
        push(pk(8'h1F, 24'hA0, 2'd1, 0, 2'd2, 16'd1, 8'h00));
        push(pk(8'h1F, 24'hB0, 2'd1, 0, 2'd2, 16'd1, 8'h10));
      end
      if (k == 3'd2)
        push(pk(opt ? 8'h0B : 8'h03, {8'h0, col}, 2'd2, opt ? 2'd1 : 2'd0, 2'd1, 16'(len), 0));
    end
    act_n = 0; busy_left = nbusy; final_st = st;
    @(negedge clk);
    req_valid = 1; req_kind = k; req_opt = opt; req_row = row; req_col = col; req_len = len;
    @(negedge clk);
    req_valid = 0;
    seen = 0;
    for (int c = 0; c < 4000 && !seen; c++) begin
      @(negedge clk);
      if (intrude && c == 3) begin req_valid = 1; req_kind = 3'd4; end
      if (intrude && c == 4) req_valid = 0;
      if (done) begin
        seen = 1;
        chk(!busy, {tag, " R11 busy low at done"}, 64'(busy), 0);
      end
    end
    chk(seen, {tag, " R11 done seen"}, 64'(seen), 1);
    rsl = exp_result(k, st, tmo);
    chk(result == rsl, {tag, " R9 result"}, 64'(result), 64'(rsl));
    chk(act_n == exp_n, {tag, " op count"}, 64'(act_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < act_n; i++)
      chk(act_log[i] == exp_log[i], $sformatf("%s op %0d", tag, i),
          64'(act_log[i]), 64'(exp_log[i]));
    @(negedge clk);
    chk(!done && result == rsl, {tag, " R11 pulse/hold"}, 64'({done, result}), 64'(rsl));
  endtask

  task automatic expect_ignored(logic [2:0] k, string tag);
    bit moved;
    act_n = 0; moved = 0;
    @(negedge clk);
    req_valid = 1; req_kind = k; req_row = 24'h123;
    @(negedge clk);
    req_valid = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (busy || op_valid) moved = 1;
    end
    chk(!moved && act_n == 0, tag, 64'(act_n), 0);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] rk;
    void'($urandom(32'd91));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !op_valid, "R1 reset state", 64'({busy, done, op_valid}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !op_valid, "R1 after release", 64'({busy, done, op_valid}), 0);
    expect_ignored(3'd2, "R1 read refused before init");
    poll_limit = 16'd3;
    run_req(3'd0, 0, 0, 0, 0, 5, 8'h00, 0, "R8 reset timeout");
    expect_ignored(3'd4, "R1 erase refused after failed init");
    poll_limit = 16'd6;
    run_req(3'd0, 0, 0, 0, 0, 2, 8'h00, 0, "R2 reset");
    expect_ignored(3'd6, "R11 kind 6 ignored");
    run_req(3'd1, 0, 0, 0, 13'd7, 0, 8'h00, 0, "R3 ident clamp");
    run_req(3'd1, 0, 0, 0, 13'd2, 0, 8'h00, 0, "R3 ident short");
    run_req(3'd2, 0, 24'h01_2345, 16'h0040, 13'd2048, 1, 8'h00, 0, "R4 read ecc0");
    run_req(3'd2, 1, 24'h00_0100, 16'h0800, 13'd64, 0, 8'h10, 0, "R4 fast ecc1");
    run_req(3'd2, 0, 24'h3F_FFFF, 16'h0000, 13'd16, 3, 8'h20, 0, "R9 read ecc2");
    run_req(3'd2, 1, 24'h00_0007, 16'h0001, 13'd1, 0, 8'h30, 0, "R9 read ecc3");
    run_req(3'd3, 0, 24'h00_4444, 16'h0010, 13'd512, 2, 8'h08, 0, "R5 program fail");
    run_req(3'd3, 1, 24'h00_4445, 16'h0000, 13'd100, 0, 8'h00, 1, "R11 program busy-ignore");
    run_req(3'd4, 0, 24'h00_0C00, 0, 0, 4, 8'h04, 0, "R6 erase fail");
    run_req(3'd4, 0, 24'h00_0C40, 0, 0, 6, 8'h00, 0, "R8 erase timeout");
    poll_limit = 16'd1;
    run_req(3'd3, 0, 24'h00_0001, 0, 13'd4, 1, 8'h00, 0, "R8 limit one");
    poll_limit = 16'd5;
    for (int n = 0; n < 30; n++) begin
      rk = 3'(1 + ($urandom % 4));
      run_req(rk, 1'($urandom), 24'($urandom), 16'($urandom), 13'(1 + $urandom % 4096),
              $urandom % 7, {2'($urandom), 6'($urandom) & 6'h3E}, 0,
              "R7 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule